// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns stereo PCM samples into the three-wire stream that a serial audio DAC expects: a bit clock, a word-select line that marks which channel is on the wire, and a serial data line. Every frame has 64 bit clocks, split into a left slot and a right slot of 32 bit clocks each. The left slot always comes first. Within each slot the sample is sent most significant bit first.

A two-bit format input picks one of three framings: a one-bit-delayed framing (I2S), left-justified or right-justified. The framings differ only in where the word sits relative to the word-select edge. A width input sets the sample width, from 16 to 24 bits. The bit clock is made by dividing a master-clock enable strobe, so every output changes on an enabled master-clock cycle of the system clock.

One left/right pair is loaded per frame through a valid/ready handshake into a single holding register. If the holding register is empty when a frame begins, the previous pair is sent again and an underrun strobe is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: `mode_i` selects the framing: 0 = I2S, 1 = left-justified, 2 = right-justified, and 3 behaves exactly like 0. A frame is 64 bit clocks: the left slot (slot bits 0..31) comes first, then the right slot (slot bits 32..63).
- R2: In I2S framing, `ws_o` is low for the left slot and high for the right slot. The MSB is sent in slot bit 1 (one bit clock after the `ws_o` change), and all other slot bits are 0.
- R3: In left-justified framing, `ws_o` is high for the left slot and low for the right slot. The MSB is sent in slot bit 0, and the slot bits after the LSB are 0.
- R4: In right-justified framing, `ws_o` is high for the left slot. Only the 16 most significant bits of the sample are sent, in slot bits 16..31, so the LSB falls in the last bit clock before the next `ws_o` change. Slot bits 0..15 are 0.
- R5: The effective width W is `width_i` limited to the range 16..24 (below 16 gives 16, above 24 gives 24). The sample is taken from bits [W-1:0] of the 24-bit sample input, and higher bits are ignored. Transmission is MSB first in every framing.
- R6: `sd_o` and `ws_o` change only in the cycle in which `sck_o` falls. They stay constant while `sck_o` is high, so the receiver samples them on the rising edge.
- R7: `sck_o` toggles once every HALF_DIV (default 2) cycles in which `mclk_en_i` is high. It holds its value, and so do the other serial outputs, in cycles where `mclk_en_i` is low.
- R8: A pair is accepted when `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only while the one-entry holding register is empty. The accepted pair is sent in the next frame that starts.
- R9: If no pair is held when a frame starts, the previous pair is sent again. `underrun_o` is high for exactly one cycle, in the cycle of the `sck_o` fall that opens that frame.
- R10: `mode_i` and `width_i` are sampled only at the `sck_o` fall that opens a left slot. Changes at any other time do not affect the frame in progress.
- R11: While `rst_ni` is low, `sck_o` is high, `ws_o` is high, `sd_o` is low, `underrun_o` is low and `s_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master-clock enable strobe |
| mode_i | input | 2 | Framing select |
| width_i | input | 5 | Requested sample width in bits |
| s_valid_i | input | 1 | Sample pair valid |
| s_ready_o | output | 1 | Holding register empty |
| s_left_i | input | 24 | Left sample |
| s_right_i | input | 24 | Right sample |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle strobe for a repeated frame |

## Verification
The assertions do not constrain the inputs: `mode_i` and `width_i` may change in any cycle, `mclk_en_i` may have any pattern, and `s_valid_i` may be raised whether or not `s_ready_o` is high. The only assumption is that `rst_ni` is low from time zero until the clock runs. The stimulus uses this freedom deliberately:
- It changes the format and width in the middle of frames.
- It drives the invalid width codes 5 and 30 and the spare format code 3.
- It stops `mclk_en_i` for a stretch and also runs it at half rate.
- It withholds a sample for a whole frame to force a repeat.

The driver raises `s_valid_i` only in a cycle where it has seen `s_ready_o` high, and holds it for one cycle. Because of this, each accepted pair maps to exactly one frame, and the scoreboard can line up its expected frames with the ones it decodes.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  function automatic int unsigned clamp_w(int unsigned w, int unsigned lo, int unsigned hi);
    if (w < lo) return lo;
    if (w > hi) return hi;
    return w;
  endfunction

endpackage

// File: rtl/aser_sck_gen.sv
module aser_sck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_en_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          turn;

  assign turn = mclk_en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (mclk_en_i) begin
      if (turn) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign fall_o = turn && sck_q;
endmodule

// File: rtl/aser_frame_ctl.sv
module aser_frame_ctl
  import audio_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned MIN_W    = 16,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned WW       = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fall_i,
  input  fmt_e                fmt_i,
  input  logic [WW-1:0]       width_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ready_o,
  output logic [CNT_W-1:0]    bit_o,
  output fmt_e                fmt_o,
  output logic [WW-1:0]       width_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                underrun_o
);
  logic [CNT_W-1:0]    bit_q;
  logic                hold_v;
  logic [SAMPLE_W-1:0] hold_l, hold_r, act_l, act_r;
  fmt_e                fmt_q;
  logic [WW-1:0]       wid_q, wid_c;
  logic                ur_q;
  logic                frame_start;

  // last bit of the right slot wraps into a new left slot
  assign frame_start = fall_i && (bit_q == '1);
  assign wid_c = WW'(clamp_w(int'(width_i), MIN_W, SAMPLE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '1;
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
      fmt_q  <= FMT_I2S;
      wid_q  <= WW'(SAMPLE_W);
      ur_q   <= 1'b0;
    end else begin
      ur_q <= 1'b0;
      if (fall_i) bit_q <= bit_q + 1'b1;
      if (valid_i && !hold_v) begin
        hold_v <= 1'b1;
        hold_l <= left_i;
        hold_r <= right_i;
      end
      if (frame_start) begin
        fmt_q <= fmt_i;
        wid_q <= wid_c;
        if (hold_v) begin
          act_l  <= hold_l;
          act_r  <= hold_r;
          hold_v <= 1'b0;
        end else begin
          ur_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o    = ~hold_v;
  assign bit_o      = bit_q;
  assign fmt_o      = fmt_q;
  assign width_o    = wid_q;
  assign left_o     = act_l;
  assign right_o    = act_r;
  assign underrun_o = ur_q;
endmodule

// File: rtl/aser_bit_sel.sv
module aser_bit_sel
  import audio_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RJ_W     = 16,
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned WW       = 5
) (
  input  logic [CNT_W-1:0]    bit_i,
  input  fmt_e                fmt_i,
  input  logic [WW-1:0]       width_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                ws_o,
  output logic                sd_o
);
  localparam int unsigned SLW   = CNT_W - 1;
  localparam int          RJ_AT = int'(SLOT_W - RJ_W);

  logic                right_slot, hit;
  logic [SAMPLE_W-1:0] smp, shifted;
  int                  k, w, sh;

  always_comb begin
    right_slot = bit_i[CNT_W-1];
    smp        = right_slot ? right_i : left_i;
    k          = int'(bit_i[SLW-1:0]);
    w          = int'(width_i);
    hit        = 1'b0;
    sh         = 0;
    unique case (fmt_i)
      FMT_LJ: begin
        hit = (k < w);
        sh  = w - 1 - k;
      end
      FMT_RJ: begin
        hit = (k >= RJ_AT);
        sh  = w - 1 - (k - RJ_AT);
      end
      default: begin // one-bit delay
        hit = (k >= 1) && (k <= w);
        sh  = w - k;
      end
    endcase
    shifted = '0;
    sd_o    = 1'b0;
    if (hit) begin
      shifted = smp >> sh;
      sd_o    = shifted[0];
    end
    ws_o = (fmt_i == FMT_LJ || fmt_i == FMT_RJ) ? ~right_slot : right_slot;
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter  int unsigned SAMPLE_W = 24,
  parameter  int unsigned MIN_W    = 16,
  parameter  int unsigned RJ_W     = 16,
  parameter  int unsigned SLOT_W   = 32,
  parameter  int unsigned HALF_DIV = 2,
  localparam int unsigned WW       = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mclk_en_i,
  input  logic [1:0]          mode_i,
  input  logic [WW-1:0]       width_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                sck_o,
  output logic                ws_o,
  output logic                sd_o,
  output logic                underrun_o
);
  localparam int unsigned CNT_W = $clog2(2 * SLOT_W);

  logic                fall;
  logic [CNT_W-1:0]    bit_idx;
  fmt_e                fmt_act;
  logic [WW-1:0]       wid_act;
  logic [SAMPLE_W-1:0] act_l, act_r;

  aser_sck_gen #(.HALF_DIV(HALF_DIV)) i_sck_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mclk_en_i(mclk_en_i),
    .sck_o    (sck_o),
    .fall_o   (fall)
  );

  aser_frame_ctl #(
    .SAMPLE_W(SAMPLE_W), .MIN_W(MIN_W), .CNT_W(CNT_W), .WW(WW)
  ) i_frame_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall),
    .fmt_i     (fmt_e'(mode_i)),
    .width_i   (width_i),
    .valid_i   (s_valid_i),
    .left_i    (s_left_i),
    .right_i   (s_right_i),
    .ready_o   (s_ready_o),
    .bit_o     (bit_idx),
    .fmt_o     (fmt_act),
    .width_o   (wid_act),
    .left_o    (act_l),
    .right_o   (act_r),
    .underrun_o(underrun_o)
  );

  aser_bit_sel #(
    .SAMPLE_W(SAMPLE_W), .RJ_W(RJ_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .WW(WW)
  ) i_bit_sel (
    .bit_i  (bit_idx),
    .fmt_i  (fmt_act),
    .width_i(wid_act),
    .left_i (act_l),
    .right_i(act_r),
    .ws_o   (ws_o),
    .sd_o   (sd_o)
  );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mclk_en_i,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic sck_o,
  input logic ws_o,
  input logic sd_o,
  input logic underrun_o
);
  p_steady_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> ($stable(sd_o) && $stable(ws_o)));

  p_ws_on_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ws_o) |-> $fell(sck_o));

  p_sck_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mclk_en_i |=> $stable(sck_o));

  p_accept_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  p_ur_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);

  p_ur_at_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> $fell(sck_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk i_audio_ser_tx_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mclk_en_i (mclk_en_i),
  .s_valid_i (s_valid_i),
  .s_ready_o (s_ready_o),
  .sck_o     (sck_o),
  .ws_o      (ws_o),
  .sd_o      (sd_o),
  .underrun_o(underrun_o)
);

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mclk_en = 1'b1;
  logic        pulse_en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [4:0]  width = 5'd24;
  logic        valid = 1'b0;
  logic [23:0] left = '0, right = '0;
  logic        ready, sck, ws, sd, ur;
  bit          done = 1'b0;

  always #10 clk = ~clk;
  always @(negedge clk) if (pulse_en) mclk_en <= ~mclk_en;

  audio_ser_tx i_audio_ser_tx (
    .clk_i(clk), .rst_ni(rst_ni), .mclk_en_i(mclk_en), .mode_i(mode),
    .width_i(width), .s_valid_i(valid), .s_ready_o(ready), .s_left_i(left),
    .s_right_i(right), .sck_o(sck), .ws_o(ws), .sd_o(sd), .underrun_o(ur)
  );

  typedef struct {logic [23:0] l; logic [23:0] r; bit u;} item_t;
  item_t       exp_q[$];
  logic [23:0] last_l = '0, last_r = '0;
  int          n_chk = 0, n_bad = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge
  task automatic send(logic [23:0] l, logic [23:0] r);
    while (!ready) @(negedge clk);
    valid = 1'b1; left = l; right = r;
    exp_q.push_back('{l, r, 1'b0});
    last_l = l; last_r = r;
    @(negedge clk);
    valid = 1'b0;
  endtask

  function automatic logic [31:0] slot_of(int m, int w, logic [23:0] s);
    int we;
    logic [31:0] v;
    we = (w < 16) ? 16 : (w > 24) ? 24 : w;
    v = {8'h00, s} & ((32'h1 << we) - 1);
    if (m == 1) return v << (32 - we);
    if (m == 2) return (v >> (we - 16)) & 32'h0000_FFFF;
    return v << (31 - we);
  endfunction

  task automatic check_frame(int m, int w, bit u, logic [63:0] sd_v, logic [63:0] ws_v);
    item_t it;
    logic [31:0] ls, rs;
    logic [63:0] e_sd, e_ws;
    string tag;
    if (exp_q.size() == 0) return;
    it = exp_q.pop_front();
    ls = slot_of(m, w, it.l);
    rs = slot_of(m, w, it.r);
    for (int i = 0; i < 32; i++) begin
      e_sd[i]      = ls[31-i];
      e_sd[32+i]   = rs[31-i];
      e_ws[i]      = (m == 1 || m == 2);
      e_ws[32+i]   = !(m == 1 || m == 2);
    end
    tag = (m == 1) ? "R3" : (m == 2) ? "R4" : (m == 3) ? "R1" : "R2";
    if (w < 16 || w > 24) tag = {tag, " R5 clamp"};
    check(sd_v == e_sd, {tag, " data"}, sd_v, e_sd);
    check(ws_v == e_ws, {tag, " R1 ws"}, ws_v, e_ws);
    check(u == it.u, "R9 underrun flag", 64'(u), 64'(it.u));
  endtask

  // monitor: decode frames from the serial pins
  initial begin
    logic prev;
    int idx, fm, fw;
    bit fu, started;
    logic [63:0] sd_v, ws_v;
    prev = 1'b1; idx = 0; fm = 0; fw = 24; fu = 1'b0; started = 1'b0;
    sd_v = '0; ws_v = '0;
    wait (rst_ni);
    forever begin
      @(posedge clk); #2;
      if (done) break;
      if (prev && !sck && idx == 0) begin
        fm = int'(mode); fw = int'(width); fu = ur; started = 1'b1;   // R10 config at left slot start
      end
      if (!prev && sck && started) begin
        sd_v[idx] = sd; ws_v[idx] = ws;
        idx++;
        if (idx == 64) begin
          idx = 0;
          check_frame(fm, fw, fu, sd_v, ws_v);
        end
      end
      prev = sck;
    end
  end

  task automatic wait_rise();
    logic p;
    p = sck;
    forever begin
      @(negedge clk);
      if (sck && !p) break;
      p = sck;
    end
  endtask

  initial begin
    int cyc;
    logic s0, w0, d0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(sck == 1'b1, "R11 sck", 64'(sck), 64'd1);
    check(ws == 1'b1, "R11 ws", 64'(ws), 64'd1);
    check(sd == 1'b0, "R11 sd", 64'(sd), 64'd0);
    check(ur == 1'b0, "R11 underrun", 64'(ur), 64'd0);
    check(ready == 1'b1, "R11 ready", 64'(ready), 64'd1);
    rst_ni = 1'b1;

    // R2 I2S, 24 bit
    send(24'h800001, 24'h7FFFFE);
    send(24'hA5C3F0, 24'h0F1E2D);
    send(24'hFFFFFF, 24'h000000);
    // R10 width change in mid frame
    repeat (100) @(negedge clk);
    width = 5'd16;
    send(24'h12ABCD, 24'hFF8001);
    send(24'h005555, 24'h00AAAA);
    // R1 spare code acts as I2S
    mode = 2'd3; width = 5'd20;
    send(24'h0C3A5F, 24'hF81234);
    // R3 left-justified
    mode = 2'd1;
    send(24'h8F0F0F, 24'h70F0F1);
    send(24'h000001, 24'hFFFFFF);
    width = 5'd30;  // R5 clamp high
    send(24'hC00003, 24'h3FFFFC);
    width = 5'd5;   // R5 clamp low
    send(24'hFE8001, 24'h017FFE);
    // R4 right-justified truncation
    mode = 2'd2; width = 5'd24;
    send(24'hABCDEF, 24'h13579B);
    send(24'h800000, 24'h0000FF);
    width = 5'd16;
    send(24'h00C3A5, 24'h00FFFF);
    // R10 mode change in mid frame
    repeat (120) @(negedge clk);
    mode = 2'd0; width = 5'd24;
    send(24'h654321, 24'h9ABCDE);
    // R9 underrun: hold back one frame
    while (!ready) @(negedge clk);
    repeat (300) @(negedge clk);
    exp_q.push_back('{last_l, last_r, 1'b1});
    send(24'h111111, 24'hEEEEEE);
    send(24'h2468AC, 24'hDB9753);

    // R7 bit clock period
    wait_rise();
    cyc = 0;
    begin
      logic p;
      p = sck;
      forever begin
        @(negedge clk); cyc++;
        if (sck && !p) break;
        p = sck;
      end
    end
    check(cyc == 4, "R7 sck period", 64'(cyc), 64'd4);

    // R7 outputs frozen without enable
    mclk_en = 1'b0;
    s0 = sck; w0 = ws; d0 = sd;
    repeat (40) @(negedge clk);
    check(sck == s0, "R7 sck frozen", 64'(sck), 64'(s0));
    check({ws, sd} == {w0, d0}, "R7 ws/sd frozen", 64'({ws, sd}), 64'({w0, d0}));
    mclk_en = 1'b1;

    // R8 R6 half-rate enable
    pulse_en = 1'b1;
    send(24'h0A0B0C, 24'hF0E0D0);
    send(24'h7FFFFF, 24'h800000);
    pulse_en = 1'b0;
    @(negedge clk);
    mclk_en = 1'b1;
    send(24'h3C3C3C, 24'hC3C3C3);

    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    check(exp_q.size() == 0, "R8 all pairs sent", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: R8 queue=%0d expected 0", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule